// File: doc/BRIEF.md
# Unary Register Dependency Matrix

This block keeps, for every function unit and every architectural register, a record of whether that unit will read the register as a source or write it as a destination. Register numbers arrive in one-hot (unary) form when an instruction issues. Each intersection of unit and register is one small cell. The cell reserves the register for its unit, and it flags a conflict when a different unit issues an instruction that touches the same register.

The matrix has two jobs. At issue time it reports hazards for the issuing unit. A read-after-write hazard means the new instruction reads a register that another unit is still going to write. A write-after-read hazard means the new instruction writes a register that another unit still has to read. Later, when the unit's read or write is granted, the matrix drives one select line per register so the register file can be accessed. On the clock edge that ends the grant cycle, the reservation is released.

All behaviour uses one rising clock edge. Reservations are captured on the issue edge. The select lines are combinational during the grant cycle. The release takes effect on the edge that closes that cycle. Ordering between function units and the register file itself are handled elsewhere.

Top module: `udm_matrix`

## Requirements
- R1: On a rising edge where `issue_i[u]` is high, unit u records every register whose bit is high in `dest_i` as a write reservation. It records every register whose bit is high in `src1_i` or `src2_i` as a read reservation. Reservations held from earlier issues are kept unless they are released.
- R2: `rd_pend_o[u]` is high in a cycle where `issue_i[u]` is high if some other unit holds a write reservation on a register whose bit is high in `src1_i` or `src2_i`.
- R3: `wr_pend_o[u]` is high in a cycle where `issue_i[u]` is high if some other unit holds a read reservation on the register whose bit is high in `dest_i`.
- R4: `rd_sel_o[r]` is high while `go_rd_i[u]` is high and unit u holds a read reservation on register r. The results for all units are ORed per register.
- R5: `wr_sel_o[r]` is high while `go_wr_i[u]` is high and unit u holds a write reservation on register r. The results for all units are ORed per register.
- R6: On the edge that ends a cycle with `go_rd_i[u]` high, all read reservations of unit u are released. `go_wr_i[u]` does the same for the write reservations of unit u. Once released, a reservation causes no hazard and no select.
- R7: If unit u both issues and receives a go signal in the same cycle, the bits carried by the new issue are reserved. All older reservations of that kind for unit u are released.
- R8: A unit's own reservations never raise its own pending flags. `rd_pend_o` and `wr_pend_o` are low for any unit whose `issue_i` bit is low.
- R9: While `rst_n` is low at a rising edge, all reservations are cleared. After reset, all outputs are low until something issues.
- R10: Hazards are judged against the reservations held before the current edge. A reservation that is being released in the current grant cycle still raises a hazard for an instruction issuing in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | NUM_FU | Issue strobe per function unit, at most one high |
| dest_i | input | NUM_REG | One-hot destination register of the issuing instruction |
| src1_i | input | NUM_REG | One-hot first source register of the issuing instruction |
| src2_i | input | NUM_REG | One-hot second source register of the issuing instruction |
| go_rd_i | input | NUM_FU | Read grant per unit, at most one high |
| go_wr_i | input | NUM_FU | Write grant per unit, at most one high |
| rd_pend_o | output | NUM_FU | Read-after-write hazard for the issuing unit |
| wr_pend_o | output | NUM_FU | Write-after-read hazard for the issuing unit |
| rd_sel_o | output | NUM_REG | Register file read select, one bit per register |
| wr_sel_o | output | NUM_REG | Register file write select, one bit per register |

## Verification
The event of interest is a grant that releases a reservation arriving in the same cycle as a new issue. The issue may come from another unit that conflicts with the released register, or from the granted unit itself. Directed cycles set up both cases: one unit issues against a register whose grant is active, and another unit issues and is granted on the same edge. The random phase drives issue and both grant vectors independently every cycle, so these coincidences recur many times. Each cycle the bench compares hazards and selects against a reference model. The reference model evaluates hazards on the reservations held before the edge and applies new bits ahead of the release.

// File: rtl/udm_pkg.sv
// Package: shared definitions for the unary register dependency matrix.
// Assumes: nothing beyond a single clock domain.
package udm_pkg;

    parameter int unsigned UDM_NUM_FU_DEF  = 4;
    parameter int unsigned UDM_NUM_REG_DEF = 8;

    // Reservation state held by one cell.
    typedef struct packed {
        logic wr;   // write reservation (destination)
        logic rd1;  // read reservation via first source
        logic rd2;  // read reservation via second source
    } udm_resv_t;

endpackage

// File: rtl/udm_cell.sv
// Module: udm_cell
// One unit/register intersection. It captures the unary destination and
// source bits on issue and drives this register's select contribution
// while a grant is active. It releases the reservation at the edge that
// ends the grant cycle, and reports the raw conflict terms against
// another unit's issue.
// Assumes: the unary bits are stable around the clock edge; new bits
// captured at issue win over a release in the same cycle.
module udm_cell
    import udm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic dest_bit_i,
    input  logic src1_bit_i,
    input  logic src2_bit_i,
    input  logic go_rd_i,
    input  logic go_wr_i,
    output logic raw_o,
    output logic war_o,
    output logic rd_sel_o,
    output logic wr_sel_o
);

    udm_resv_t resv_q;
    udm_resv_t resv_d;
    udm_resv_t new_bits;

    // Bits this cell reserves on the current edge.
    always_comb begin
        new_bits.wr  = issue_i & dest_bit_i;
        new_bits.rd1 = issue_i & src1_bit_i;
        new_bits.rd2 = issue_i & src2_bit_i;
    end

    // Next state: new reservations set, grants release the older ones.
    always_comb begin
        resv_d.wr  = new_bits.wr  | (resv_q.wr  & ~go_wr_i);
        resv_d.rd1 = new_bits.rd1 | (resv_q.rd1 & ~go_rd_i);
        resv_d.rd2 = new_bits.rd2 | (resv_q.rd2 & ~go_rd_i);
    end

    // Reservation register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    // Conflict terms and select contributions from the held state.
    always_comb begin
        raw_o    = resv_q.wr & (src1_bit_i | src2_bit_i);
        war_o    = (resv_q.rd1 | resv_q.rd2) & dest_bit_i;
        rd_sel_o = go_rd_i & (resv_q.rd1 | resv_q.rd2);
        wr_sel_o = go_wr_i & resv_q.wr;
    end

    // R1
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && dest_bit_i) |=> resv_q.wr);

    // R6
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr_i && !(issue_i && dest_bit_i)) |=> !resv_q.wr);

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd_i && !issue_i) |=> !(resv_q.rd1 || resv_q.rd2));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && !go_rd_i && !go_wr_i) |=> $stable(resv_q));

endmodule

// File: rtl/udm_sel_merge.sv
// Module: udm_sel_merge
// ORs the select contributions of every unit in each register column,
// producing one read select and one write select per register.
// Assumes: at most one read grant and one write grant at a time, so the
// OR never mixes two units' selections.
module udm_sel_merge #(
    parameter int unsigned NUM_FU  = 4,
    parameter int unsigned NUM_REG = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_FU-1:0]                go_rd_i,
    input  logic [NUM_FU-1:0]                go_wr_i,
    input  logic [NUM_FU-1:0][NUM_REG-1:0]   rd_part_i,
    input  logic [NUM_FU-1:0][NUM_REG-1:0]   wr_part_i,
    output logic [NUM_REG-1:0]               rd_sel_o,
    output logic [NUM_REG-1:0]               wr_sel_o
);

    for (genvar r = 0; r < NUM_REG; r++) begin : g_col
        // Column OR of the per-unit contributions for register r.
        always_comb begin
            rd_sel_o[r] = 1'b0;
            wr_sel_o[r] = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                rd_sel_o[r] = rd_sel_o[r] | rd_part_i[f][r];
                wr_sel_o[r] = wr_sel_o[r] | wr_part_i[f][r];
            end
        end
    end

    // R4
    rd_sel_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_sel_o) |-> (|go_rd_i));

    // R5
    wr_sel_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_sel_o) |-> (|go_wr_i));

endmodule

// File: rtl/udm_hazard_reduce.sv
// Module: udm_hazard_reduce
// For each unit, folds the conflict terms of all other units' cells over
// every register column into one read-pending and one write-pending flag.
// The flags are qualified by that unit's issue strobe.
// Assumes: the conflict terms are computed against the issuing
// instruction's unary bits, which are shared by every row.
module udm_hazard_reduce #(
    parameter int unsigned NUM_FU  = 4,
    parameter int unsigned NUM_REG = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_FU-1:0]                issue_i,
    input  logic [NUM_FU-1:0][NUM_REG-1:0]   raw_i,
    input  logic [NUM_FU-1:0][NUM_REG-1:0]   war_i,
    output logic [NUM_FU-1:0]                rd_pend_o,
    output logic [NUM_FU-1:0]                wr_pend_o
);

    logic [NUM_FU-1:0] raw_row;
    logic [NUM_FU-1:0] war_row;

    // Per-unit OR across registers.
    always_comb begin
        for (int g = 0; g < NUM_FU; g++) begin
            raw_row[g] = |raw_i[g];
            war_row[g] = |war_i[g];
        end
    end

    for (genvar f = 0; f < NUM_FU; f++) begin : g_unit
        logic raw_other;
        logic war_other;

        // OR over every row except this unit's own.
        always_comb begin
            raw_other = 1'b0;
            war_other = 1'b0;
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f) begin
                    raw_other = raw_other | raw_row[g];
                    war_other = war_other | war_row[g];
                end
            end
        end

        // Qualify with the issuing unit's strobe.
        always_comb begin
            rd_pend_o[f] = issue_i[f] & raw_other;
            wr_pend_o[f] = issue_i[f] & war_other;
        end
    end

    // R8
    pend_one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_i) |-> ($onehot0(rd_pend_o) && $onehot0(wr_pend_o)));

endmodule

// File: rtl/udm_matrix.sv
// Module: udm_matrix
// Top of the unary register dependency matrix: a NUM_FU x NUM_REG grid
// of cells. It also contains the per-unit hazard reduction and the
// per-register select merge.
// Assumes: issue_i, go_rd_i and go_wr_i are each at most one-hot;
// dest_i, src1_i and src2_i are one-hot or zero.
module udm_matrix
    import udm_pkg::*;
#(
    parameter int unsigned NUM_FU  = UDM_NUM_FU_DEF,
    parameter int unsigned NUM_REG = UDM_NUM_REG_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FU-1:0]  issue_i,
    input  logic [NUM_REG-1:0] dest_i,
    input  logic [NUM_REG-1:0] src1_i,
    input  logic [NUM_REG-1:0] src2_i,
    input  logic [NUM_FU-1:0]  go_rd_i,
    input  logic [NUM_FU-1:0]  go_wr_i,
    output logic [NUM_FU-1:0]  rd_pend_o,
    output logic [NUM_FU-1:0]  wr_pend_o,
    output logic [NUM_REG-1:0] rd_sel_o,
    output logic [NUM_REG-1:0] wr_sel_o
);

    logic [NUM_FU-1:0][NUM_REG-1:0] raw_grid;
    logic [NUM_FU-1:0][NUM_REG-1:0] war_grid;
    logic [NUM_FU-1:0][NUM_REG-1:0] rd_part;
    logic [NUM_FU-1:0][NUM_REG-1:0] wr_part;

    for (genvar f = 0; f < NUM_FU; f++) begin : g_row
        for (genvar r = 0; r < NUM_REG; r++) begin : g_cell
            udm_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .issue_i    (issue_i[f]),
                .dest_bit_i (dest_i[r]),
                .src1_bit_i (src1_i[r]),
                .src2_bit_i (src2_i[r]),
                .go_rd_i    (go_rd_i[f]),
                .go_wr_i    (go_wr_i[f]),
                .raw_o      (raw_grid[f][r]),
                .war_o      (war_grid[f][r]),
                .rd_sel_o   (rd_part[f][r]),
                .wr_sel_o   (wr_part[f][r])
            );
        end
    end

    udm_hazard_reduce #(
        .NUM_FU  (NUM_FU),
        .NUM_REG (NUM_REG)
    ) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_i),
        .raw_i     (raw_grid),
        .war_i     (war_grid),
        .rd_pend_o (rd_pend_o),
        .wr_pend_o (wr_pend_o)
    );

    udm_sel_merge #(
        .NUM_FU  (NUM_FU),
        .NUM_REG (NUM_REG)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_rd_i   (go_rd_i),
        .go_wr_i   (go_wr_i),
        .rd_part_i (rd_part),
        .wr_part_i (wr_part),
        .rd_sel_o  (rd_sel_o),
        .wr_sel_o  (wr_sel_o)
    );

    // R4
    go_rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_rd_i));

    // R5
    go_wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_wr_i));

    // R9
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_sel_o == '0 && wr_sel_o == '0 &&
                          rd_pend_o == '0 && wr_pend_o == '0));

endmodule

// File: tb/test_udm_matrix.sv
`timescale 1ns/1ps
module test_udm_matrix;

    localparam int NF = 4;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] issue_i = '0;
    logic [NR-1:0] dest_i = '0, src1_i = '0, src2_i = '0;
    logic [NF-1:0] go_rd_i = '0, go_wr_i = '0;
    logic [NF-1:0] rd_pend_o, wr_pend_o;
    logic [NR-1:0] rd_sel_o, wr_sel_o;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model of the reservations.
    logic [NF-1:0][NR-1:0] m_wr = '0, m_r1 = '0, m_r2 = '0;

    always #2.5 clk = ~clk;

    udm_matrix #(.NUM_FU(NF), .NUM_REG(NR)) i_udm_matrix (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .dest_i(dest_i),
        .src1_i(src1_i), .src2_i(src2_i), .go_rd_i(go_rd_i), .go_wr_i(go_wr_i),
        .rd_pend_o(rd_pend_o), .wr_pend_o(wr_pend_o),
        .rd_sel_o(rd_sel_o), .wr_sel_o(wr_sel_o)
    );

    function automatic logic [NF-1:0] exp_rd_pend();
        logic [NF-1:0] v = '0;
        for (int f = 0; f < NF; f++)
            for (int g = 0; g < NF; g++)
                if (g != f && issue_i[f] && |(m_wr[g] & (src1_i | src2_i))) v[f] = 1'b1;
        return v;
    endfunction

    function automatic logic [NF-1:0] exp_wr_pend();
        logic [NF-1:0] v = '0;
        for (int f = 0; f < NF; f++)
            for (int g = 0; g < NF; g++)
                if (g != f && issue_i[f] && |((m_r1[g] | m_r2[g]) & dest_i)) v[f] = 1'b1;
        return v;
    endfunction

    function automatic logic [NR-1:0] exp_rd_sel();
        logic [NR-1:0] v = '0;
        for (int f = 0; f < NF; f++) if (go_rd_i[f]) v |= m_r1[f] | m_r2[f];
        return v;
    endfunction

    function automatic logic [NR-1:0] exp_wr_sel();
        logic [NR-1:0] v = '0;
        for (int f = 0; f < NF; f++) if (go_wr_i[f]) v |= m_wr[f];
        return v;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle, compare against the model, then advance the model.
    task automatic apply(input logic [NF-1:0] iss, input logic [NR-1:0] d,
                         input logic [NR-1:0] s1, input logic [NR-1:0] s2,
                         input logic [NF-1:0] grd, input logic [NF-1:0] gwr);
        @(negedge clk);
        issue_i = iss; dest_i = d; src1_i = s1; src2_i = s2;
        go_rd_i = grd; go_wr_i = gwr;
        #1;
        chk(32'(rd_pend_o), 32'(exp_rd_pend()), "R2 R8 R10 rd_pend");
        chk(32'(wr_pend_o), 32'(exp_wr_pend()), "R3 R8 R10 wr_pend");
        chk(32'(rd_sel_o),  32'(exp_rd_sel()),  "R1 R4 R6 rd_sel");
        chk(32'(wr_sel_o),  32'(exp_wr_sel()),  "R1 R5 R6 R7 wr_sel");
        @(posedge clk);
        for (int f = 0; f < NF; f++) begin
            m_wr[f] = ({NR{iss[f]}} & d)  | (m_wr[f] & ~{NR{gwr[f]}});
            m_r1[f] = ({NR{iss[f]}} & s1) | (m_r1[f] & ~{NR{grd[f]}});
            m_r2[f] = ({NR{iss[f]}} & s2) | (m_r2[f] & ~{NR{grd[f]}});
        end
    endtask

    function automatic logic [NR-1:0] oh_reg(input int pct);
        if (($urandom % 100) < pct) return NR'(1) << ($urandom % NR);
        return '0;
    endfunction

    function automatic logic [NF-1:0] oh_fu(input int pct);
        if (($urandom % 100) < pct) return NF'(1) << ($urandom % NF);
        return '0;
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset clears everything, even with grants requested.
        repeat (3) @(posedge clk);
        @(negedge clk);
        go_rd_i = 4'b0001; go_wr_i = 4'b0001;
        #1;
        chk(32'(rd_sel_o), 0, "R9 rd_sel after reset");
        chk(32'(wr_sel_o), 0, "R9 wr_sel after reset");
        rst_n = 1'b1;
        go_rd_i = '0; go_wr_i = '0;

        // Unit 0: dest r3, sources r1 and r2.
        apply(4'b0001, 8'h08, 8'h02, 8'h04, 4'b0000, 4'b0000);
        // R2: unit 1 reads r3.
        apply(4'b0010, 8'h20, 8'h08, 8'h00, 4'b0000, 4'b0000);
        chk(32'(rd_pend_o), 32'h2, "R2 directed raw");
        // R3: unit 2 writes r1, which unit 0 still reads.
        apply(4'b0100, 8'h02, 8'h00, 8'h00, 4'b0000, 4'b0000);
        // R4 R5 R10: grants while unit 3 writes r2.
        apply(4'b1000, 8'h04, 8'h00, 8'h00, 4'b0001, 4'b0010);
        // R6: unit 0 read reservations gone.
        apply(4'b0000, 8'h00, 8'h00, 8'h00, 4'b0001, 4'b0000);
        // R7: unit 2 issues dest r6 while its dest r1 is granted.
        apply(4'b0100, 8'h40, 8'h00, 8'h00, 4'b0000, 4'b0100);
        // R8: unit 2 reads its own destination r6.
        apply(4'b0100, 8'h00, 8'h40, 8'h00, 4'b0000, 4'b0000);
        // R7: only r6 remains for unit 2.
        apply(4'b0000, 8'h00, 8'h00, 8'h00, 4'b0000, 4'b0100);

        // Random phase.
        for (int i = 0; i < 3000; i++)
            apply(oh_fu(50), oh_reg(80), oh_reg(70), oh_reg(50), oh_fu(30), oh_fu(30));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule